// File: doc/BRIEF.md
# Packed Shift and Pack Unit

This is a combinational 32-bit unit for data rearrangement. It shifts packed lanes, narrows words into halfwords, packs bytes and joins two words at a bit or byte boundary. It takes two source words (`src_a`, `src_b`), a 5-bit immediate amount and a 4-bit operation select, and returns one result word in the same cycle. No state is kept, so a result depends only on the inputs present at that moment.

The lane shifts work on `src_b`. Their register-supplied variants take the shift amount from the low bits of `src_a`, so one source port serves as both operand and amount. The rounding variants add back the last bit shifted out. The result keeps only the lane width, so a lane that overflows wraps.

Top module: `pk_shift_pack`

## Requirements
- R1: The operation codes on `op_sel` are: 0 byte arithmetic shift, 1 byte arithmetic shift with rounding, 2 and 3 are the same two with a register amount, 4 halfword logical shift, 5 halfword logical shift with a register amount, 6 word shift-and-pack, 7 word shift-and-pack with rounding, 8 byte pack, 9 append, 10 prepend, 11 byte align. Codes 12 to 15 give a result of zero.
- R2: Byte arithmetic shift (codes 0 and 2) shifts each of the four bytes of `src_b` right by 0 to 7 and fills with the byte's sign bit.
- R3: In the rounding byte shifts (codes 1 and 3), when bit (amount-1) of a source byte is 1, 1 is added to that shifted byte, and the sum wraps within 8 bits.
- R4: A byte shift amount of 0 returns every byte of `src_b` unchanged, with or without rounding.
- R5: Register-amount byte shifts take the amount from `src_a[2:0]`. The higher bits of `src_a` and all of `imm_amt` have no effect.
- R6: Halfword logical shift shifts both halfwords of `src_b` right on their own, with zero fill. The amount is `imm_amt[3:0]` (code 4) or `src_a[3:0]` (code 5).
- R7: Shift-and-pack shifts `src_b` and `src_a` arithmetically by `imm_amt[4:0]`, using the rounding rule of R3 for code 7. Bits 15:0 of the shifted `src_b` go to `result[31:16]`, and bits 15:0 of the shifted `src_a` go to `result[15:0]`.
- R8: Byte pack returns, from the top byte down, `src_a[23:16]`, `src_a[7:0]`, `src_b[23:16]`, `src_b[7:0]`.
- R9: Append returns `src_b` shifted left by sa=`imm_amt`, ORed with the low sa bits of `src_a`.
- R10: Prepend returns `src_a` shifted left by 32-sa, ORed with `src_b` shifted right by sa. When sa is 0 it returns `src_b`.
- R11: Byte align uses bp=`imm_amt[1:0]`. When bp is 0 it returns `src_b`. Otherwise it returns `src_b` shifted left by 8*bp, ORed with `src_a` shifted right by 8*(4-bp).
- R12: The amount bits an operation does not use have no effect. These are `imm_amt[4:3]` for immediate byte shifts, `imm_amt[4]` for immediate halfword shifts, `imm_amt[4:2]` for byte align, and all of `imm_amt` for byte pack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| src_a | input | 32 | First source word; also supplies the register shift amount |
| src_b | input | 32 | Second source word; the data for the lane shifts |
| imm_amt | input | 5 | Immediate shift amount, pointer or field width |
| result | output | 32 | Result word |

## Verification
The unit holds no state, so a fault shows up as a wrong bit in `result` for the same input vector, with no delay. The likely faults are a wrong shift amount (for example, amount bits taken from the wrong field), a round bit read from the wrong position, or a lane boundary that leaks. Each of these appears only for some lanes, amounts or sign patterns. For that reason the bench mixes hand-worked vectors with rounding and wrap values against a bench model over many amount and data combinations, and it sets the ignored amount bits on purpose.

// File: rtl/pk_shift_pack.sv
module pk_shift_pack (
  input  logic [3:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [4:0]  imm_amt,
  output logic [31:0] result
);
  localparam logic [3:0] OP_BSRA    = 4'd0;
  localparam logic [3:0] OP_BSRA_R  = 4'd1;
  localparam logic [3:0] OP_BSRAV   = 4'd2;
  localparam logic [3:0] OP_BSRAV_R = 4'd3;
  localparam logic [3:0] OP_HSRL    = 4'd4;
  localparam logic [3:0] OP_HSRLV   = 4'd5;
  localparam logic [3:0] OP_PSRA    = 4'd6;
  localparam logic [3:0] OP_PSRA_R  = 4'd7;
  localparam logic [3:0] OP_BPACK   = 4'd8;
  localparam logic [3:0] OP_APPEND  = 4'd9;
  localparam logic [3:0] OP_PREPEND = 4'd10;
  localparam logic [3:0] OP_BALIGN  = 4'd11;
  localparam int NBYTE = 4;
  localparam int NHALF = 2;

  logic        rnd;
  logic [2:0]  bsh;
  logic [3:0]  hsh;
  logic [1:0]  bp;
  logic [31:0] byte_sra, half_srl, pack_sra, app_w, pre_w, aln_w, mask;
  logic [16:0] wb_sh, wa_sh;

  assign rnd = (op_sel == OP_BSRA_R) || (op_sel == OP_BSRAV_R) || (op_sel == OP_PSRA_R);
  assign bsh = ((op_sel == OP_BSRAV) || (op_sel == OP_BSRAV_R)) ? src_a[2:0] : imm_amt[2:0];
  assign hsh = (op_sel == OP_HSRLV) ? src_a[3:0] : imm_amt[3:0];
  assign bp  = imm_amt[1:0];

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    logic signed [8:0] ext;
    assign ext = $signed({src_b[8*i +: 8], 1'b0}) >>> bsh;
    assign byte_sra[8*i +: 8] = ext[8:1] + {7'd0, rnd & ext[0]};
  end

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    assign half_srl[16*i +: 16] = src_b[16*i +: 16] >> hsh;
  end

  assign wb_sh    = 17'($signed({src_b, 1'b0}) >>> imm_amt);
  assign wa_sh    = 17'($signed({src_a, 1'b0}) >>> imm_amt);
  assign pack_sra = {wb_sh[16:1] + {15'd0, rnd & wb_sh[0]},
                     wa_sh[16:1] + {15'd0, rnd & wa_sh[0]}};

  assign mask  = (32'd1 << imm_amt) - 32'd1;
  assign app_w = (src_b << imm_amt) | (src_a & mask);
  assign pre_w = (imm_amt == 5'd0) ? src_b
               : (src_a << (6'd32 - {1'b0, imm_amt})) | (src_b >> imm_amt);
  assign aln_w = (bp == 2'd0) ? src_b
               : (src_b << {bp, 3'b000}) | (src_a >> {3'd4 - {1'b0, bp}, 3'b000});

  always_comb begin
    case (op_sel)
      OP_BSRA, OP_BSRA_R, OP_BSRAV, OP_BSRAV_R: result = byte_sra;
      OP_HSRL, OP_HSRLV:                        result = half_srl;
      OP_PSRA, OP_PSRA_R:                       result = pack_sra;
      OP_BPACK:   result = {src_a[23:16], src_a[7:0], src_b[23:16], src_b[7:0]};
      OP_APPEND:  result = app_w;
      OP_PREPEND: result = pre_w;
      OP_BALIGN:  result = aln_w;
      default:    result = 32'd0;
    endcase
  end
endmodule

// File: rtl/pk_shift_pack_chk.sv
module pk_shift_pack_chk (
  input logic [3:0]  op_sel,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic [4:0]  imm_amt,
  input logic [31:0] result
);
  logic [31:0] keep_lo, keep_hi;
  assign keep_lo = ~(32'hFFFF_FFFF << imm_amt);
  assign keep_hi = 32'hFFFF_FFFF >> imm_amt;

  always_comb begin
    if (op_sel >= 4'd12)
      p_reserved_zero_r1: assert (result == 32'd0) else $error("reserved op gave nonzero");
    if ((op_sel == 4'd0 || op_sel == 4'd1) && imm_amt[2:0] == 3'd0)
      p_byte_zero_shift_r4: assert (result == src_b) else $error("zero byte shift altered data");
    if (op_sel == 4'd4)
      p_half_div_r6: assert (result[31:16] == src_b[31:16] / (17'd1 << imm_amt[3:0])
                             && result[15:0] == src_b[15:0] / (17'd1 << imm_amt[3:0]))
        else $error("halfword shift mismatch");
    if (op_sel == 4'd9)
      p_append_fields_r9: assert ((((result ^ src_a) & keep_lo) == 32'd0)
                                  && ((result >> imm_amt) == (src_b & keep_hi)))
        else $error("append field mismatch");
    if (op_sel == 4'd10 && imm_amt == 5'd0)
      p_prepend_zero_r10: assert (result == src_b) else $error("prepend zero changed B");
    if (op_sel == 4'd11 && imm_amt[1:0] == 2'd0)
      p_align_zero_r11: assert (result == src_b) else $error("align zero changed B");
  end
endmodule

bind pk_shift_pack pk_shift_pack_chk u_chk (.*);

// File: tb/pk_shift_pack_bench.sv
`timescale 1ns/1ps
module pk_shift_pack_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  op_sel = 4'd15;
  logic [31:0] src_a = 32'd0, src_b = 32'd0;
  logic [4:0]  imm_amt = 5'd0;
  logic [31:0] result;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pk_shift_pack u_pk_shift_pack (.op_sel(op_sel), .src_a(src_a), .src_b(src_b),
                                 .imm_amt(imm_amt), .result(result));

  function automatic logic [31:0] m_bsra(input logic [31:0] b, input int amt, input bit rnd);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      logic signed [7:0] s;
      int v;
      s = b[8*l +: 8];
      v = s;
      if (amt != 0) begin
        v = v >>> amt;
        if (rnd && b[8*l + amt - 1]) v = v + 1;
      end
      r[8*l +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [15:0] m_wsra(input logic [31:0] w, input int amt, input bit rnd);
    longint v;
    v = longint'($signed(w));
    if (amt != 0) begin
      v = v >>> amt;
      if (rnd && w[amt-1]) v = v + 1;
    end
    return v[15:0];
  endfunction

  function automatic logic [31:0] m_half(input logic [31:0] b, input int amt);
    logic [15:0] hi, lo;
    hi = b[31:16]; lo = b[15:0];
    for (int k = 0; k < amt; k++) begin hi = {1'b0, hi[15:1]}; lo = {1'b0, lo[15:1]}; end
    return {hi, lo};
  endfunction

  function automatic logic [31:0] m_append(input logic [31:0] a, input logic [31:0] b, input int sa);
    logic [31:0] r;
    r = b << sa;
    for (int k = 0; k < sa; k++) r[k] = a[k];
    return r;
  endfunction

  function automatic logic [31:0] m_prepend(input logic [31:0] a, input logic [31:0] b, input int sa);
    logic [63:0] cat;
    if (sa == 0) return b;
    cat = {a, b} >> sa;
    return cat[31:0];
  endfunction

  function automatic logic [31:0] m_align(input logic [31:0] a, input logic [31:0] b, input int p);
    logic [63:0] cat;
    cat = {b, a} << (8 * p);
    return cat[63:32];
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] amt);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; imm_amt = amt;
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] exp);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h amt=%0d actual=%h expected=%h",
               tag, op_sel, src_a, src_b, imm_amt, result, exp);
    end
  endtask

  task automatic t_reset_reserved();
    apply(4'd15, 32'd0, 32'd0, 5'd0);            chk("R1 idle", 32'd0);
    for (int op = 12; op < 16; op++) begin
      apply(op[3:0], 32'hDEAD_BEEF, 32'h1234_5678, 5'd7); chk("R1 reserved", 32'd0);
    end
  endtask

  task automatic t_byte_shift();
    apply(4'd0, 32'd0, 32'h7FFF_8001, 5'd1);     chk("R2 hand", 32'h3FFF_C000);
    apply(4'd1, 32'd0, 32'h7FFF_8001, 5'd1);     chk("R3 round wrap", 32'h4000_C001);
    apply(4'd0, 32'd0, 32'h80F0_7F0F, 5'd7);     chk("R2 amt7", 32'hFFFF_0000);
    apply(4'd1, 32'd0, 32'h9C5A_3366, 5'd0);     chk("R4 zero round", 32'h9C5A_3366);
    for (int n = 0; n < 200; n++) begin
      logic [31:0] b; logic [4:0] amt;
      b = $urandom; amt = 5'($urandom);
      apply(4'd0, 32'd0, b, amt); chk("R2 model", m_bsra(b, int'(amt[2:0]), 0));
      apply(4'd1, 32'd0, b, amt); chk("R3 model", m_bsra(b, int'(amt[2:0]), 1));
    end
  endtask

  task automatic t_byte_var();
    for (int n = 0; n < 100; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      apply(4'd2, a, b, 5'($urandom)); chk("R5 var", m_bsra(b, int'(a[2:0]), 0));
      apply(4'd3, a, b, 5'($urandom)); chk("R5 var round", m_bsra(b, int'(a[2:0]), 1));
    end
  endtask

  task automatic t_half();
    apply(4'd4, 32'd0, 32'h8000_FFFF, 5'd15);    chk("R6 hand", 32'h0001_0001);
    for (int n = 0; n < 100; n++) begin
      logic [31:0] a, b; logic [4:0] amt;
      a = $urandom; b = $urandom; amt = 5'($urandom);
      apply(4'd4, a, b, amt); chk("R6 imm", m_half(b, int'(amt[3:0])));
      apply(4'd5, a, b, amt); chk("R6 var", m_half(b, int'(a[3:0])));
    end
  endtask

  task automatic t_pack();
    apply(4'd7, 32'hFFFF_8000, 32'h0001_2345, 5'd4); chk("R7 hand", 32'h1234_F800);
    apply(4'd7, 32'h0000_0001, 32'h0000_0003, 5'd1); chk("R7 round", 32'h0002_0001);
    apply(4'd6, 32'h0000_0001, 32'h0000_0003, 5'd1); chk("R7 trunc", 32'h0001_0000);
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b; logic [4:0] amt;
      a = $urandom; b = $urandom; amt = 5'($urandom);
      apply(4'd6, a, b, amt); chk("R7 model", {m_wsra(b, int'(amt), 0), m_wsra(a, int'(amt), 0)});
      apply(4'd7, a, b, amt); chk("R7 model round", {m_wsra(b, int'(amt), 1), m_wsra(a, int'(amt), 1)});
    end
  endtask

  task automatic t_bpack();
    apply(4'd8, 32'h1122_3344, 32'h5566_7788, 5'd0);  chk("R8", 32'h2244_6688);
    apply(4'd8, 32'h1122_3344, 32'h5566_7788, 5'd31); chk("R12 bpack amt", 32'h2244_6688);
  endtask

  task automatic t_append_prepend_align();
    apply(4'd9, 32'hFFFF_FFFF, 32'h0000_00A5, 5'd4);  chk("R9 hand", 32'h0000_0A5F);
    apply(4'd9, 32'hFFFF_FFFF, 32'h1234_5678, 5'd0);  chk("R9 zero", 32'h1234_5678);
    apply(4'd10, 32'h0000_000F, 32'hABCD_0000, 5'd4); chk("R10 hand", 32'hFABC_D000);
    apply(4'd10, 32'hFFFF_FFFF, 32'h1234_5678, 5'd0); chk("R10 zero", 32'h1234_5678);
    apply(4'd11, 32'hAABB_CCDD, 32'h1122_3344, 5'd1); chk("R11 hand", 32'h2233_44AA);
    apply(4'd11, 32'hAABB_CCDD, 32'h1122_3344, 5'd0); chk("R11 zero", 32'h1122_3344);
    for (int n = 0; n < 100; n++) begin
      logic [31:0] a, b; logic [4:0] amt;
      a = $urandom; b = $urandom; amt = 5'($urandom);
      apply(4'd9, a, b, amt);  chk("R9 model", m_append(a, b, int'(amt)));
      apply(4'd10, a, b, amt); chk("R10 model", m_prepend(a, b, int'(amt)));
      apply(4'd11, a, b, amt); chk("R11 model", m_align(a, b, int'(amt[1:0])));
    end
  endtask

  task automatic t_ignored_bits();
    apply(4'd0, 32'hFFFF_FFFF, 32'h80C0_4020, 5'b11_010); chk("R12 byte imm", 32'hE0F0_1008);
    apply(4'd2, 32'hFFFF_FFFA, 32'h80C0_4020, 5'b11_111); chk("R5 upper a", 32'hE0F0_1008);
    apply(4'd4, 32'd0, 32'hF000_0F00, 5'b1_0100);         chk("R12 half imm", 32'h0F00_00F0);
    apply(4'd11, 32'hAABB_CCDD, 32'h1122_3344, 5'b11101); chk("R12 align", 32'h2233_44AA);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_reserved();
    t_byte_shift();
    t_byte_var();
    t_half();
    t_pack();
    t_bpack();
    t_append_prepend_align();
    t_ignored_bits();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule